// File: doc/BRIEF.md
# Buffered Program Write Buffer

This block collects a burst of data writes for a flash buffered-program operation and then copies them into the memory array. After the command decoder reports that the buffered-program setup command was seen (`arm`), the next write carries a word count. That write sizes the buffer and clears it. The writes that follow fill the buffer. Each write lands at an offset measured from the address of the first data write.

The fill ends when the buffer has taken its full length, or when a write falls outside the buffer window. That closing write must carry the confirm code. When the code is correct, the engine checks the lock state of the base block. If the block is unlocked, the engine copies the bytes it has collected into the array, one byte per cycle, while `busy` is high. A wrong code or a locked block sets a sticky error flag instead, and nothing reaches the array. In every case the read side is switched to status mode after the closing write.

Top module: `bpb_engine`

## Requirements
- R1: After reset, `busy`, `arr_we`, `status_mode`, `err_seq` and `err_lock` are all 0, and the engine is idle.
- R2: The first accepted write after `arm` is the sizing write. Its `wr_data[15:0]` holds a count, and the buffer length becomes min((count+1)*4, MAX_BYTES) bytes. The written-byte counter is reset, and every buffer byte is cleared to zero, so gaps that are never written are later copied as 0x00.
- R3: A data write made while the written counter is zero latches `wr_addr` as the base pointer, which appears on `lock_addr`. Byte lane i of `wr_data` (bits 8i+7:8i, lane 0 lowest) is stored at offset (wr_addr - base)+i when `wr_be[i]` is set. The counter advances by the number of set enables.
- R4: A fill write whose address is below the base pointer, or whose offset is MAX_BYTES or more, stores nothing and is treated as the closing write.
- R5: Once the counter has reached the buffer length, the next write is the closing write. A closing write whose `wr_data[7:0]` equals CONFIRM (default 8'hD0), with `blk_locked` low, starts the commit. Any other closing code sets `err_seq` and writes nothing.
- R6: If `blk_locked` is high when a confirming write arrives, `err_lock` is set and no array write takes place.
- R7: A commit writes min(counter, length) bytes on consecutive cycles. The k-th write has `arr_addr` = base+k and `arr_byte` = buffer byte k, and `busy` is high for exactly those cycles.
- R8: After any closing write, `status_mode` is 1 and the engine is idle. While the engine is idle, writes have no effect. `arm` clears `status_mode`, `err_seq` and `err_lock`.
- R9: While `busy` is high, `arm` and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Setup command seen; the next write is the sizing write |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Byte address of the write |
| wr_data | input | 32 | Write data; carries the count or the code on control cycles |
| wr_be | input | 4 | Byte enables |
| blk_locked | input | 1 | Lock state of the block that holds `lock_addr` |
| lock_addr | output | AW | Latched base pointer, used for the lock lookup |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | AW | Array byte address |
| arr_byte | output | 8 | Array byte data |
| busy | output | 1 | Commit in progress |
| status_mode | output | 1 | Read side should return status |
| err_seq | output | 1 | Sticky: wrong closing code |
| err_lock | output | 1 | Sticky: commit refused because the block is locked |

## Verification
The bench builds the engine with AW=12 and MAX_BYTES=32. With this small buffer, a count of 15 runs into the length cap, and an offset of 32 crosses the buffer window within a handful of writes. At the same size, one earlier operation dirties the buffer, so the zero-clear of gaps becomes visible on the array port. The table covers full-length commits for several counts. Directed cases cover partial byte enables, a write below the pointer, a wrong code, a locked block, writes while idle, and `arm` during a commit.

// File: rtl/bpb_pkg.sv
package bpb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SIZE, ST_FILL} bpb_state_e;

  // bytes held by the buffer for a given word-count field
  function automatic int unsigned buf_len(input logic [15:0] cnt, input int unsigned max_b);
    int unsigned l;
    l = (int'(cnt) + 1) * 4;
    return (l > max_b) ? max_b : l;
  endfunction

  function automatic int unsigned lane_count(input logic [3:0] be);
    return $countones(be);
  endfunction
endpackage

// File: rtl/bpb_store.sv
module bpb_store #(
  parameter int MAX_BYTES = 256,
  localparam int OFF_W = $clog2(MAX_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [OFF_W-1:0] off,
  input  logic [31:0]      data,
  input  logic [3:0]       be,
  input  logic [OFF_W-1:0] rd_idx,
  output logic [7:0]       rd_byte
);
  localparam logic [OFF_W:0] MAX_I = (OFF_W+1)'(MAX_BYTES);

  logic [7:0] mem [MAX_BYTES];
  logic [OFF_W:0] lane_idx [4];
  logic [3:0] lane_ok;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign lane_idx[g] = {1'b0, off} + (OFF_W+1)'(g);
    assign lane_ok[g]  = we && be[g] && (lane_idx[g] < MAX_I);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_BYTES; i++) mem[i] <= 8'h00;
    end else if (clr) begin
      for (int i = 0; i < MAX_BYTES; i++) mem[i] <= 8'h00;
    end else begin
      for (int l = 0; l < 4; l++)
        if (lane_ok[l]) mem[lane_idx[l][OFF_W-1:0]] <= data[8*l +: 8];
    end
  end

  assign rd_byte = mem[rd_idx];

  // R2: a clear leaves every byte at zero
  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> rd_byte == 8'h00);
endmodule

// File: rtl/bpb_seq.sv
module bpb_seq #(
  parameter int AW = 16,
  parameter int MAX_BYTES = 256,
  parameter logic [7:0] CONFIRM = 8'hD0,
  localparam int OFF_W = $clog2(MAX_BYTES),
  localparam int CW = $clog2(MAX_BYTES) + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [15:0]      wr_low,
  input  logic [3:0]       wr_be,
  input  logic             blk_locked,
  input  logic             copy_busy,
  output logic [AW-1:0]    lock_addr,
  output logic             st_clr,
  output logic             st_we,
  output logic [OFF_W-1:0] st_off,
  output logic             commit_go,
  output logic [CW-1:0]    commit_n,
  output logic             status_mode,
  output logic             err_seq,
  output logic             err_lock
);
  import bpb_pkg::*;
  localparam logic [AW:0] MAX_A = (AW+1)'(MAX_BYTES);

  bpb_state_e state;
  logic [AW-1:0] ptr;
  logic [CW-1:0] len, written;

  // named internal events
  logic acc, ev_arm, ev_size, ev_store, ev_close, ev_confirm, ev_locked, ev_badcode;
  logic fresh, below, outside, full;
  logic [AW-1:0] base_now, off_full;

  assign acc      = wr_en && !copy_busy && !arm;
  assign ev_arm   = arm && !copy_busy;
  assign ev_size  = acc && state == ST_SIZE;
  assign fresh    = written == '0;
  assign base_now = fresh ? wr_addr : ptr;
  assign off_full = wr_addr - base_now;
  assign below    = wr_addr < base_now;
  assign outside  = below || ({1'b0, off_full} >= MAX_A);
  assign full     = written >= len;
  assign ev_close = acc && state == ST_FILL && (full || outside);
  assign ev_store = acc && state == ST_FILL && !(full || outside);
  assign ev_confirm = ev_close && wr_low[7:0] == CONFIRM;
  assign ev_locked  = ev_confirm && blk_locked;
  assign ev_badcode = ev_close && wr_low[7:0] != CONFIRM;

  assign commit_n  = (written < len) ? written : len;
  assign commit_go = ev_confirm && !blk_locked && commit_n != '0;
  assign st_clr    = ev_size;
  assign st_we     = ev_store;
  assign st_off    = off_full[OFF_W-1:0];
  assign lock_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ptr <= '0;
      len <= '0;
      written <= '0;
      status_mode <= 1'b0;
      err_seq <= 1'b0;
      err_lock <= 1'b0;
    end else begin
      if (ev_arm) begin
        state <= ST_SIZE;
        status_mode <= 1'b0;
        err_seq <= 1'b0;
        err_lock <= 1'b0;
      end else if (ev_size) begin
        len <= CW'(buf_len(wr_low, MAX_BYTES));
        written <= '0;
        state <= ST_FILL;
      end else if (ev_store) begin
        if (fresh) ptr <= wr_addr;
        written <= written + CW'(lane_count(wr_be));
      end else if (ev_close) begin
        state <= ST_IDLE;
        status_mode <= 1'b1;
        if (ev_badcode) err_seq <= 1'b1;
        if (ev_locked) err_lock <= 1'b1;
      end
    end
  end

  // R6: a refused commit never starts the copy
  assert_lock_no_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_locked |=> !copy_busy);
  // R8: status mode only turns on after a closing write
  assert_status_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_mode) |-> $past(ev_close));
  // R3: the byte counter only grows within one fill
  assert_written_mono_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL && $past(state == ST_FILL)) |-> written >= $past(written));
  // R9: no new commit is launched while one is running
  assert_go_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> !copy_busy);
endmodule

// File: rtl/bpb_commit.sv
module bpb_commit #(
  parameter int AW = 16,
  parameter int MAX_BYTES = 256,
  localparam int OFF_W = $clog2(MAX_BYTES),
  localparam int CW = $clog2(MAX_BYTES) + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CW-1:0]    n,
  input  logic [AW-1:0]    base,
  output logic             busy,
  output logic [OFF_W-1:0] rd_idx,
  output logic             arr_we,
  output logic [AW-1:0]    arr_addr
);
  logic [CW-1:0] idx, n_r;
  logic [AW-1:0] base_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx <= '0;
      n_r <= '0;
      base_r <= '0;
    end else if (go && !busy) begin
      busy <= 1'b1;
      idx <= '0;
      n_r <= n;
      base_r <= base;
    end else if (busy) begin
      if (idx == n_r - 1'b1) busy <= 1'b0;
      else idx <= idx + 1'b1;
    end
  end

  assign arr_we   = busy;
  assign arr_addr = base_r + AW'(idx);
  assign rd_idx   = idx[OFF_W-1:0];

  // R7: consecutive copy cycles step the array address by one
  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> arr_addr == $past(arr_addr) + 1'b1);
endmodule

// File: rtl/bpb_engine.sv
module bpb_engine #(
  parameter int AW = 16,
  parameter int MAX_BYTES = 256,
  parameter logic [7:0] CONFIRM = 8'hD0,
  localparam int OFF_W = $clog2(MAX_BYTES),
  localparam int CW = $clog2(MAX_BYTES) + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [3:0]    wr_be,
  input  logic          blk_locked,
  output logic [AW-1:0] lock_addr,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [7:0]    arr_byte,
  output logic          busy,
  output logic          status_mode,
  output logic          err_seq,
  output logic          err_lock
);
  logic st_clr, st_we, commit_go;
  logic [OFF_W-1:0] st_off, rd_idx;
  logic [CW-1:0] commit_n;

  bpb_seq #(.AW(AW), .MAX_BYTES(MAX_BYTES), .CONFIRM(CONFIRM)) u_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_low(wr_data[15:0]), .wr_be(wr_be), .blk_locked(blk_locked),
    .copy_busy(busy), .lock_addr(lock_addr), .st_clr(st_clr), .st_we(st_we),
    .st_off(st_off), .commit_go(commit_go), .commit_n(commit_n),
    .status_mode(status_mode), .err_seq(err_seq), .err_lock(err_lock));

  bpb_store #(.MAX_BYTES(MAX_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(st_clr), .we(st_we), .off(st_off),
    .data(wr_data), .be(wr_be), .rd_idx(rd_idx), .rd_byte(arr_byte));

  bpb_commit #(.AW(AW), .MAX_BYTES(MAX_BYTES)) u_commit (
    .clk(clk), .rst_n(rst_n), .go(commit_go), .n(commit_n), .base(lock_addr),
    .busy(busy), .rd_idx(rd_idx), .arr_we(arr_we), .arr_addr(arr_addr));

  // R6: the array is never written while a lock refusal stands
  assert_no_write_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !err_lock);
endmodule

// File: tb/sim_bpb_engine.sv
module sim_bpb_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int MAXB = 32;

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, wr_en = 1'b0, blk_locked = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0] wr_be = '0;
  logic [AW-1:0] lock_addr, arr_addr;
  logic arr_we, busy, status_mode, err_seq, err_lock;
  logic [7:0] arr_byte;

  int n_chk = 0, n_fail = 0, n_arr = 0;
  logic [7:0] model [2**AW];

  always #(CLK_PERIOD/2) clk = ~clk;

  bpb_engine #(.AW(AW), .MAX_BYTES(MAXB)) u0 (
    .clk(clk), .rst_n(rst_n), .arm(arm), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .blk_locked(blk_locked), .lock_addr(lock_addr),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_byte(arr_byte), .busy(busy),
    .status_mode(status_mode), .err_seq(err_seq), .err_lock(err_lock));

  always @(negedge clk) if (arr_we) begin
    model[arr_addr] = arr_byte;
    n_arr++;
  end

  typedef struct packed { logic [11:0] base; logic [15:0] cnt; logic [7:0] nw; logic [7:0] seed; } vec_t;
  localparam vec_t VECS [3] = '{
    '{12'h040, 16'd3,  8'd4, 8'h10},
    '{12'h080, 16'd15, 8'd8, 8'h40},
    '{12'h0C0, 16'd1,  8'd2, 8'h90}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [31:0] wdat(input logic [7:0] seed, input int k);
    logic [31:0] d;
    for (int i = 0; i < 4; i++) d[8*i +: 8] = seed + 8'(4*k + i);
    return d;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic pulse_arm();
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 200 && busy; t++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int len, n, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !arr_we, "R1 busy/we", {busy, arr_we}, 0);
    chk(!status_mode && !err_seq && !err_lock, "R1 status", {status_mode, err_seq, err_lock}, 0);

    // table: full-length commits (R2 sizing and cap, R3 fill, R5 confirm, R7 copy)
    foreach (VECS[v]) begin
      len = (int'(VECS[v].cnt) + 1) * 4;
      if (len > MAXB) len = MAXB;
      n = int'(VECS[v].nw) * 4;
      if (n > len) n = len;
      n_arr = 0;
      pulse_arm();
      wr('0, {16'h0, VECS[v].cnt}, 4'hF);
      for (int k = 0; k < int'(VECS[v].nw); k++)
        wr(VECS[v].base + AW'(4*k), wdat(VECS[v].seed, k), 4'hF);
      chk(lock_addr == VECS[v].base, "R3 base pointer", lock_addr, VECS[v].base);
      wr(VECS[v].base, 32'hD0, 4'hF);
      wait_idle();
      chk(n_arr == n, "R7 copy length", n_arr, n);
      bad = 0;
      for (int b = 0; b < n; b++)
        if (model[VECS[v].base + AW'(b)] != VECS[v].seed + 8'(b)) bad++;
      chk(bad == 0, "R7 copied bytes", bad, 0);
      chk(status_mode && !err_seq && !err_lock, "R8 status after commit", {status_mode, err_seq, err_lock}, 3'b100);
    end

    // R2 gap reads zero, R4 below-pointer write closes the fill
    n_arr = 0;
    pulse_arm();
    wr('0, 32'd3, 4'hF);
    wr(12'h100, 32'hA1A2A3A4, 4'hF);
    wr(12'h108, 32'hB1B2B3B4, 4'hF);
    wr(12'h0FF, 32'hD0, 4'hF);
    wait_idle();
    chk(n_arr == 8, "R4 below-pointer close copy count", n_arr, 8);
    chk({model[12'h103], model[12'h100]} == 16'hA1A4, "R3 lane placement", {model[12'h103], model[12'h100]}, 16'hA1A4);
    chk({model[12'h104], model[12'h105], model[12'h106], model[12'h107]} == 32'h0,
        "R2 gap cleared", {model[12'h104], model[12'h105], model[12'h106], model[12'h107]}, 0);

    // R3 partial byte enables
    n_arr = 0;
    pulse_arm();
    wr('0, 32'd0, 4'hF);
    wr(12'h300, 32'h11223344, 4'b0011);
    wr(12'h300, 32'h55667788, 4'b1100);
    wr(12'h300, 32'hD0, 4'hF);
    wait_idle();
    chk(n_arr == 4, "R3 enable count", n_arr, 4);
    chk({model[12'h303], model[12'h302], model[12'h301], model[12'h300]} == 32'h55663344,
        "R3 partial lanes", {model[12'h303], model[12'h302], model[12'h301], model[12'h300]}, 32'h55663344);

    // R4 offset beyond window, R5 wrong code on that close
    n_arr = 0;
    pulse_arm();
    wr('0, 32'd15, 4'hF);
    wr(12'h400, 32'h01020304, 4'hF);
    wr(12'h420, 32'h12, 4'hF);
    wait_idle();
    chk(err_seq && status_mode && n_arr == 0, "R4 out-of-window close", {err_seq, status_mode, n_arr[5:0]}, 8'hC0);

    // R5 wrong code after the buffer is full
    n_arr = 0;
    pulse_arm();
    chk(!status_mode && !err_seq, "R8 arm clears status", {status_mode, err_seq}, 0);
    wr('0, 32'd0, 4'hF);
    wr(12'h500, 32'h01020304, 4'hF);
    wr(12'h500, 32'h77, 4'hF);
    wait_idle();
    chk(err_seq && !err_lock && n_arr == 0, "R5 bad code", {err_seq, err_lock, n_arr[5:0]}, 8'h80);

    // R6 locked block at confirm
    n_arr = 0;
    pulse_arm();
    wr('0, 32'd0, 4'hF);
    wr(12'h600, 32'h01020304, 4'hF);
    chk(lock_addr == 12'h600, "R6 lock address", lock_addr, 12'h600);
    blk_locked = 1'b1;
    wr(12'h600, 32'hD0, 4'hF);
    blk_locked = 1'b0;
    wait_idle();
    chk(err_lock && !err_seq && n_arr == 0, "R6 locked refusal", {err_lock, err_seq, n_arr[5:0]}, 8'h80);

    // R8 idle writes have no effect
    wr(12'h600, 32'hD0, 4'hF);
    wr(12'h604, 32'hDEADBEEF, 4'hF);
    wait_idle();
    chk(n_arr == 0 && err_lock && status_mode && !busy, "R8 idle writes ignored", n_arr, 0);
    pulse_arm();
    chk(!err_lock && !status_mode, "R8 arm clears lock error", {err_lock, status_mode}, 0);

    // R9 arm and writes ignored during commit
    n_arr = 0;
    wr('0, 32'd7, 4'hF);
    for (int k = 0; k < 8; k++) wr(12'h700 + AW'(4*k), wdat(8'h20, k), 4'hF);
    wr(12'h700, 32'hD0, 4'hF);
    chk(busy, "R7 busy after confirm", busy, 1);
    pulse_arm();
    wr(12'h700, 32'h0, 4'hF);
    wait_idle();
    chk(status_mode && n_arr == 32, "R9 arm ignored while busy", n_arr, 32);
    bad = 0;
    for (int b = 0; b < 32; b++) if (model[12'h700 + AW'(b)] != 8'h20 + 8'(b)) bad++;
    chk(bad == 0, "R9 data intact", bad, 0);

    report();
  end
endmodule